// File: doc/BRIEF.md
# Serial Address and Segment Loader

This block receives display contents from a host processor over a four-wire serial link and turns them into row writes for an 8-row by 64-column display memory. One select pin picks the word type. When it is high, an 8-bit address word is shifted in. This word names the target row and carries a 2-bit chip-select field. When the pin is low, a 64-bit segment word is shifted in instead. A level-sensitive latch pin commits whichever word was shifted last. Committing an address arms the block, provided the chip-select field matches the strap pins. Committing segment data then writes the whole 64-bit word into the armed row.

All serial pins, plus the power-on hold pin, pass through synchronizers into the system clock domain. Edges are detected in that domain, so the system clock must run several times faster than the serial clock. Several of these blocks can share one serial bus. Each block is given a different strap value, and only the block whose strap matches the address field accepts the following data.

Top module: `seg_loader`

## Requirements
- R1: After reset, wr_en is 0, wr_row is 0, wr_data is all zeros, and no address is accepted.
- R2: Each rising edge of sck shifts sdi into the address register when addr_sel is 1, or into the segment register when addr_sel is 0. The other register keeps its contents.
- R3: The first address bit shifted in becomes address bit 0. Bits 2:0 are the row, bit 3 is compared with strap_cs[0], bit 4 is compared with strap_cs[1], bit 5 must be 1, and bits 7:6 are ignored.
- R4: A latch commit in address mode accepts the address only if bits 4:3 equal strap_cs and bit 5 is 1. Otherwise the block is disarmed, and segment commits write nothing until an address is accepted.
- R5: The first segment bit shifted in appears on wr_data[63], and the last one appears on wr_data[0].
- R6: A falling edge of latch_in in segment mode, while armed, gives a one-cycle wr_en pulse on the third rising clk edge after the fall. The pulse carries wr_row equal to the armed row and wr_data equal to the last 64 bits shifted, including bits shifted while latch_in was high.
- R7: A latch commit in address mode never raises wr_en.
- R8: A segment commit made before any address has been accepted since reset writes nothing.
- R9: While por_hold is high, sck edges and latch_in falls are ignored. Nothing shifts, nothing is written, and the armed row is unchanged.
- R10: An accepted address stays in force for any number of later segment writes, until the next address commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_hold | input | 1 | Power-on hold; while high, serial input is ignored |
| strap_cs | input | 2 | Chip identity compared against the address select field |
| sck | input | 1 | Serial shift clock, rising edge active |
| sdi | input | 1 | Serial data |
| addr_sel | input | 1 | 1 selects the address word, 0 selects the segment word |
| latch_in | input | 1 | Level-type commit; the falling edge commits |
| wr_en | output | 1 | One-cycle row write strobe |
| wr_row | output | 3 | Row of the write (the armed row) |
| wr_data | output | SEG_W | Segment word, bit 63 first shifted |

## Verification
Input changes reach the edge detectors two clk edges later, and the write strobe is registered one edge after that. A latch fall therefore produces wr_en at the third rising clk edge and clears it at the fourth. The bench drives inputs on falling clk edges and holds each serial phase for three clock cycles, so every shift edge is seen. After each latch fall it samples at exactly the third falling edge for the strobe, row and data, and at the fourth for the strobe's end. Address commits and ignored commits are sampled at the same point, where the strobe must be low. A bench-side memory filled from every strobe is compared with a row model at the end, which also catches any stray writes.

// File: rtl/seg_loader.sv
module seg_loader #(
  parameter int SEG_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_hold,
  input  logic [1:0]       strap_cs,
  input  logic             sck,
  input  logic             sdi,
  input  logic             addr_sel,
  input  logic             latch_in,
  output logic             wr_en,
  output logic [2:0]       wr_row,
  output logic [SEG_W-1:0] wr_data
);
  localparam int AW  = 8;
  localparam int NIN = 5;
  localparam int TOP = SYNC_STAGES - 1;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic           sck_s, sdi_s, latch_s, ad_s, por_s;
  logic           sck_q, latch_q;
  logic           sck_rise, latch_fall;
  logic [AW-1:0]  addr_sr;
  logic [SEG_W-1:0] seg_sr;
  logic [2:0]     row_q;
  logic           sel_ok;
  logic           addr_hit;

  assign raw = {por_hold, addr_sel, latch_in, sdi, sck};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sck_s   = sync_q[TOP][0];
  assign sdi_s   = sync_q[TOP][1];
  assign latch_s = sync_q[TOP][2];
  assign ad_s    = sync_q[TOP][3];
  assign por_s   = sync_q[TOP][4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      latch_q <= latch_s;
    end
  end

  assign sck_rise   = sck_s & ~sck_q & ~por_s;
  assign latch_fall = ~latch_s & latch_q & ~por_s;
  assign addr_hit   = addr_sr[5] && (addr_sr[4:3] == strap_cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr <= '0;
      seg_sr  <= '0;
    end else if (sck_rise) begin
      if (ad_s) addr_sr <= {sdi_s, addr_sr[AW-1:1]};
      else      seg_sr  <= {seg_sr[SEG_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      sel_ok  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (latch_fall) begin
        if (ad_s) begin
          sel_ok <= addr_hit;
          if (addr_hit) row_q <= addr_sr[2:0];
        end else if (sel_ok) begin
          wr_en   <= 1'b1;
          wr_data <= seg_sr;
        end
      end
    end
  end

  assign wr_row = row_q;

endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_row,
  input logic       por_s,
  input logic       sel_ok,
  input logic       ad_s
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R6
  AST_WE_ARMED: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> sel_ok); // R4
  AST_WE_NOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !$past(ad_s)); // R7
  AST_POR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) por_s |=> !wr_en); // R9
  AST_POR_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n) por_s |=> $stable(wr_row)); // R9
  AST_ROW_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $stable(wr_row)); // R10
endmodule

bind seg_loader seg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
  .por_s(por_s), .sel_ok(sel_ok), .ad_s(ad_s)
);

// File: tb/test_seg_loader.sv
module test_seg_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por = 1'b0;
  logic [1:0]  strap = 2'd0;
  logic        sck = 1'b0, sdi = 1'b0, ad = 1'b0, latch = 1'b0;
  logic        wr_en;
  logic [2:0]  wr_row;
  logic [63:0] wr_data;

  int nchk = 0, nfail = 0, pulses = 0, exp_pulses = 0;
  logic [63:0] ram [8];
  logic [63:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_loader i_seg_loader (
    .clk(clk), .rst_n(rst_n), .por_hold(por), .strap_cs(strap),
    .sck(sck), .sdi(sdi), .addr_sel(ad), .latch_in(latch),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en === 1'b1) begin
    ram[wr_row] = wr_data;
    pulses++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; tick(3); sck = 1'b1; tick(3); sck = 1'b0;
  endtask

  task automatic send_addr(input logic [2:0] row, input logic [1:0] cs, input logic d1, input logic [1:0] dd);
    logic [7:0] w;
    w = {dd, d1, cs, row};
    ad = 1'b1;
    for (int i = 0; i < 8; i++) shift_bit(w[i]);
  endtask

  task automatic send_data(input logic [63:0] d, input int n);
    ad = 1'b0;
    for (int i = n - 1; i >= 0; i--) shift_bit(d[i]);
  endtask

  task automatic commit(input bit exp_wr, input logic [2:0] row, input logic [63:0] data, input string req);
    latch = 1'b1; tick(3); latch = 1'b0;
    tick(3);
    chk(wr_en === exp_wr, req, 64'(wr_en), 64'(exp_wr));
    if (exp_wr) begin
      chk(wr_row === row, req, 64'(wr_row), 64'(row));
      chk(wr_data === data, req, wr_data, data);
      model[row] = data;
      exp_pulses++;
    end
    tick(1);
    chk(wr_en === 1'b0, req, 64'(wr_en), 64'd0);
    tick(2);
  endtask

  function automatic logic [63:0] pat(input int k);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ (64'(k) << 7);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] d0, d1, x;
    for (int r = 0; r < 8; r++) begin ram[r] = '0; model[r] = '0; end
    tick(3);
    chk(wr_en === 1'b0 && wr_row === 3'd0 && wr_data === 64'd0, "R1 reset", {wr_data[59:0], wr_row, wr_en}, 64'd0);
    rst_n = 1'b1;
    tick(3);

    strap = 2'd2;
    send_data(pat(100), 64);
    commit(1'b0, 3'd0, 64'd0, "R8 data before address");

    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [2:0] row;
        row = 3'((s * 4 + c) % 8);
        strap = 2'(s);
        send_addr(row, 2'(c), 1'b1, 2'(c));
        commit(1'b0, row, 64'd0, "R7 address commit");
        send_data(pat(s * 4 + c), 64);
        commit(c == s, row, pat(s * 4 + c), "R4 strap match sweep");
      end
    end

    strap = 2'd1;
    send_addr(3'd5, 2'd1, 1'b1, 2'd3);
    commit(1'b0, 3'd5, 64'd0, "R7 address commit");
    send_addr(3'd6, 2'd1, 1'b0, 2'd0);
    commit(1'b0, 3'd6, 64'd0, "R3 bit5 clear");
    send_data(pat(50), 64);
    commit(1'b0, 3'd6, 64'd0, "R4 rejected address disarms");

    for (int r = 0; r < 8; r++) begin
      send_addr(3'(r), 2'd1, 1'b1, 2'(r));
      commit(1'b0, 3'(r), 64'd0, "R7 address commit");
      send_data(pat(20 + r), 64);
      commit(1'b1, 3'(r), pat(20 + r), "R6 row write");
      send_data(pat(40 + r), 64);
      commit(1'b1, 3'(r), pat(40 + r), "R10 address persists");
    end

    send_addr(3'd2, 2'd1, 1'b1, 2'd0);
    commit(1'b0, 3'd2, 64'd0, "R7 address commit");
    send_data(64'h8000_0000_0000_0000, 64);
    commit(1'b1, 3'd2, 64'h8000_0000_0000_0000, "R5 first bit to msb");
    send_data(64'h0000_0000_0000_0001, 64);
    commit(1'b1, 3'd2, 64'h0000_0000_0000_0001, "R5 last bit to lsb");

    latch = 1'b1;
    send_data(pat(60), 64);
    commit(1'b1, 3'd2, pat(60), "R6 shift while latch high");

    d0 = pat(61);
    send_data(d0, 64);
    commit(1'b1, 3'd2, d0, "R6 row write");
    send_addr(3'd4, 2'd1, 1'b1, 2'd2);
    commit(1'b0, 3'd4, 64'd0, "R7 address commit");
    x = pat(62);
    send_data(x, 56);
    commit(1'b1, 3'd4, {d0[7:0], x[55:0]}, "R2 address shifts leave segment register");

    send_addr(3'd3, 2'd1, 1'b1, 2'd1);
    commit(1'b0, 3'd3, 64'd0, "R7 address commit");
    d1 = pat(63);
    send_data(d1, 64);
    commit(1'b1, 3'd3, d1, "R6 row write");
    por = 1'b1; tick(4);
    send_addr(3'd6, 2'd1, 1'b1, 2'd0);
    commit(1'b0, 3'd6, 64'd0, "R9 address ignored in hold");
    send_data(pat(64), 64);
    commit(1'b0, 3'd3, 64'd0, "R9 data ignored in hold");
    por = 1'b0; tick(4);
    x = pat(65);
    send_data(x, 32);
    commit(1'b1, 3'd3, {d1[31:0], x[31:0]}, "R9 no shift and row kept in hold");

    for (int r = 0; r < 8; r++)
      chk(ram[r] === model[r], "R6 memory contents", ram[r], model[r]);
    chk(pulses == exp_pulses, "R6 write count", 64'(pulses), 64'(exp_pulses));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule